// File: doc/BRIEF.md
# Branch Hazard Control Unit

This unit steers instruction fetch around conditional branches in a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). The branch condition and its destination are only settled when the branch sits in the memory stage. Until then the unit must either hold fetch back or guess a direction. Later it must repair a wrong guess by redirecting the program counter and turning the wrong-path work into bubbles.

The handling scheme is fixed at build time by a 2-bit parameter: 0 freezes fetch until the outcome is known, 1 always guesses not taken, 2 always guesses taken, and 3 guesses from the sign of the branch offset (backward taken, forward not taken). The decoder supplies a branch flag and the offset sign. The memory stage supplies the outcome, the resolved destination and the fall-through address. The unit returns a PC source code, a fetch hold, three pipeline-register bubble controls and a count of wasted fetch slots. The unit tracks its own branches through execute and memory, so a branch that gets squashed on the wrong path never acts later.

Top module: `branch_hazard_ctrl`

## Requirements
- R1: After a synchronous active-low reset the unit drives pc_sel 0, all three flushes and fetch_stall low, and lost_cycles 0.
- R2: Freeze policy: in the cycle a branch is in decode and in the cycle after, fetch_stall and flush_ifid are 1 and pc_sel is 0.
- R3: Freeze policy: two cycles after decode, the unit redirects whatever the outcome, with pc_sel 2 when taken and 3 when not taken, and all three flushes set. A later stall never follows without this redirect.
- R4: Not-taken policy: a branch in decode causes no action, pc_sel is never 1, and a not-taken outcome causes no action.
- R5: Under a predicting policy, a wrong guess acts in the memory cycle of the branch. pc_sel is 2 (resolved destination) if the branch was taken and 3 (fall-through) if not, and flush_ifid, flush_idex and flush_exmem are all set in that same cycle.
- R6: Taken policy: a branch in decode gives pc_sel 1 and flush_ifid only, with no stall. The slot fetched in that cycle is always discarded.
- R7: Taken policy: a taken outcome causes no action in the memory cycle. A not-taken outcome redirects with pc_sel 3.
- R8: Direction policy: id_offset_neg 1 behaves as R6/R7 and id_offset_neg 0 behaves as R4/R5.
- R9: lost_cycles counts wasted fetch slots and changes only in the cycle after a flush. The cost of a branch is 3 when frozen, 0 for a correct not-taken guess, 1 for a correct taken guess, and 3 in total for any wrong guess.
- R10: A branch flag in decode while decode holds a bubble is ignored. A branch that a redirect squashes in decode or execute causes no later action. mem_taken has no effect unless a tracked branch is in the memory stage.
- R11: During a redirect, redirect_pc equals mem_target when mem_taken is 1 and mem_link_pc otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_is_branch | input | 1 | Decode stage holds a conditional branch |
| id_offset_neg | input | 1 | Sign of that branch's offset (1 = backward) |
| mem_taken | input | 1 | Resolved outcome of the branch in the memory stage |
| mem_target | input | AW | Resolved destination address |
| mem_link_pc | input | AW | Fall-through address of the branch in the memory stage |
| pc_sel | output | 2 | PC source: 0 sequential, 1 predicted destination, 2 resolved destination, 3 fall-through |
| redirect_pc | output | AW | Address to load on a redirect |
| fetch_stall | output | 1 | Hold the fetch PC this cycle |
| flush_ifid | output | 1 | Load a bubble into the fetch/decode register |
| flush_idex | output | 1 | Load a bubble into the decode/execute register |
| flush_exmem | output | 1 | Load a bubble into the execute/memory register |
| lost_cycles | output | CW | Running count of wasted fetch slots |

## Verification
Every cycle, the assertions check the shape of the control word. A redirect always carries all three flushes, a guessed-taken steer discards only the fetch slot, and stalls occur only under freeze, in pairs followed by a redirect. They also check that the wasted-slot count moves only after a flush and by at most three. Only the bench scenarios can show the per-policy costs, the choice between destination and fall-through for each outcome, the handling of offset signs, and the silence of a branch squashed behind an older wrong guess. The bench drives the same stream into all four policy variants at once.

// File: rtl/bhc_pkg.sv
// Shared encodings for the branch hazard control unit.
// Assumes: policy codes are fixed at elaboration; pc_sel codes are decoded by the fetch mux.
package bhc_pkg;

    localparam logic [1:0] POL_FREEZE = 2'd0;
    localparam logic [1:0] POL_NT     = 2'd1;
    localparam logic [1:0] POL_TAKEN  = 2'd2;
    localparam logic [1:0] POL_DIR    = 2'd3;

    typedef enum logic [1:0] {
        SEL_SEQ     = 2'd0,
        SEL_PRED    = 2'd1,
        SEL_FIX_TGT = 2'd2,
        SEL_FIX_SEQ = 2'd3
    } pc_sel_e;

    // Static guess for a decoded branch under the given policy.
    function automatic logic guess_taken(input logic [1:0] pol, input logic neg);
        case (pol)
            POL_TAKEN: return 1'b1;
            POL_DIR:   return neg;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bhc_track.sv
// Follows the unit's own branches from decode through execute to memory,
// with their static guesses, and records which decode/execute slots hold bubbles.
// Assumes: the pipeline advances every cycle apart from this unit's own flushes.
module bhc_track
    import bhc_pkg::*;
#(
    parameter logic [1:0] POLICY = POL_NT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic id_is_branch,
    input  logic id_offset_neg,
    input  logic flush_ifid,
    input  logic flush_idex,
    input  logic flush_exmem,
    output logic id_br_ok,
    output logic id_pred,
    output logic ex_br,
    output logic mem_br,
    output logic mem_pred,
    output logic id_bub,
    output logic ex_bub
);

    logic ex_pred;

    // Decode flag counts only when decode holds a real instruction.
    always_comb begin
        id_br_ok = id_is_branch && !id_bub;
        id_pred  = guess_taken(POLICY, id_offset_neg);
    end

    // Advance branch tags and bubble shadows one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_br    <= 1'b0;
            ex_pred  <= 1'b0;
            mem_br   <= 1'b0;
            mem_pred <= 1'b0;
            id_bub   <= 1'b0;
            ex_bub   <= 1'b0;
        end else begin
            ex_br    <= id_br_ok && !flush_idex;
            ex_pred  <= id_pred;
            mem_br   <= ex_br && !flush_exmem;
            mem_pred <= ex_pred;
            id_bub   <= flush_ifid;
            ex_bub   <= id_bub || flush_idex;
        end
    end

endmodule

// File: rtl/bhc_decide.sv
// Combinational policy decision: redirect on resolution, hold under freeze,
// steer to the decoded destination on a taken guess.
// Assumes: a redirect from memory outranks any decode-stage action.
module bhc_decide
    import bhc_pkg::*;
#(
    parameter logic [1:0] POLICY = POL_NT
) (
    input  logic       id_br_ok,
    input  logic       id_pred,
    input  logic       ex_br,
    input  logic       mem_br,
    input  logic       mem_pred,
    input  logic       mem_taken,
    output logic [1:0] pc_sel,
    output logic       fetch_stall,
    output logic       flush_ifid,
    output logic       flush_idex,
    output logic       flush_exmem
);

    localparam bit IS_FREEZE = (POLICY == POL_FREEZE);

    logic    redirect;
    logic    hold;
    logic    steer;
    pc_sel_e sel;

    // Pick the action for this cycle from the tracked branch positions.
    always_comb begin
        redirect = mem_br && (IS_FREEZE || (mem_pred != mem_taken));
        hold     = IS_FREEZE && (id_br_ok || ex_br) && !redirect;
        steer    = !IS_FREEZE && id_br_ok && id_pred && !redirect;
        sel      = SEL_SEQ;
        if (redirect)
            sel = mem_taken ? SEL_FIX_TGT : SEL_FIX_SEQ;
        else if (steer)
            sel = SEL_PRED;
        pc_sel      = sel;
        fetch_stall = hold;
        flush_ifid  = redirect || hold || steer;
        flush_idex  = redirect;
        flush_exmem = redirect;
    end

endmodule

// File: rtl/bhc_lost_ctr.sv
// Counts fetch slots thrown away; a flush on a slot that is already a bubble costs nothing.
// Assumes: the bubble shadows come from bhc_track and wrap-around of the count is acceptable.
module bhc_lost_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_ifid,
    input  logic          flush_idex,
    input  logic          flush_exmem,
    input  logic          id_bub,
    input  logic          ex_bub,
    output logic [CW-1:0] lost_cycles
);

    logic [1:0] step;

    // Number of real instructions discarded this cycle.
    always_comb begin
        step = {1'b0, flush_ifid}
             + {1'b0, flush_idex && !id_bub}
             + {1'b0, flush_exmem && !ex_bub};
    end

    // Accumulate discarded slots.
    always_ff @(posedge clk) begin
        if (!rst_n) lost_cycles <= '0;
        else        lost_cycles <= lost_cycles + CW'(step);
    end

endmodule

// File: rtl/branch_hazard_ctrl.sv
// Top of the branch hazard control unit: branch tracking, policy decision,
// redirect address choice and wasted-slot counter.
// Assumes: branches resolve in the memory stage; comparator and adders live elsewhere.
module branch_hazard_ctrl
    import bhc_pkg::*;
#(
    parameter logic [1:0] POLICY = POL_NT,
    parameter int         AW     = 32,
    parameter int         CW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          id_is_branch,
    input  logic          id_offset_neg,
    input  logic          mem_taken,
    input  logic [AW-1:0] mem_target,
    input  logic [AW-1:0] mem_link_pc,
    output logic [1:0]    pc_sel,
    output logic [AW-1:0] redirect_pc,
    output logic          fetch_stall,
    output logic          flush_ifid,
    output logic          flush_idex,
    output logic          flush_exmem,
    output logic [CW-1:0] lost_cycles
);

    logic id_br_ok, id_pred, ex_br, mem_br, mem_pred, id_bub, ex_bub;

    bhc_track #(.POLICY(POLICY)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .id_is_branch (id_is_branch),
        .id_offset_neg(id_offset_neg),
        .flush_ifid   (flush_ifid),
        .flush_idex   (flush_idex),
        .flush_exmem  (flush_exmem),
        .id_br_ok     (id_br_ok),
        .id_pred      (id_pred),
        .ex_br        (ex_br),
        .mem_br       (mem_br),
        .mem_pred     (mem_pred),
        .id_bub       (id_bub),
        .ex_bub       (ex_bub)
    );

    bhc_decide #(.POLICY(POLICY)) u_decide (
        .id_br_ok   (id_br_ok),
        .id_pred    (id_pred),
        .ex_br      (ex_br),
        .mem_br     (mem_br),
        .mem_pred   (mem_pred),
        .mem_taken  (mem_taken),
        .pc_sel     (pc_sel),
        .fetch_stall(fetch_stall),
        .flush_ifid (flush_ifid),
        .flush_idex (flush_idex),
        .flush_exmem(flush_exmem)
    );

    bhc_lost_ctr #(.CW(CW)) u_lost (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_ifid (flush_ifid),
        .flush_idex (flush_idex),
        .flush_exmem(flush_exmem),
        .id_bub     (id_bub),
        .ex_bub     (ex_bub),
        .lost_cycles(lost_cycles)
    );

    // Repair address follows the resolved outcome.
    always_comb redirect_pc = mem_taken ? mem_target : mem_link_pc;

endmodule

// File: rtl/bhc_checker.sv
// Cycle-level properties of the branch hazard control unit, bound to every instance.
// Assumes: reset is synchronous and active low.
module bhc_checker #(
    parameter logic [1:0] POLICY = 2'd1,
    parameter int         CW     = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    pc_sel,
    input logic          fetch_stall,
    input logic          flush_ifid,
    input logic          flush_idex,
    input logic          flush_exmem,
    input logic [CW-1:0] lost_cycles
);

    assert_fix_kills_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel[1] |-> (flush_ifid && flush_idex && flush_exmem));

    assert_steer_one_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd1) |-> (flush_ifid && !flush_idex && !flush_exmem && !fetch_stall && POLICY[1]));

    assert_stall_freeze_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> (POLICY == 2'd0 && flush_ifid && pc_sel == 2'd0));

    assert_stall_pairs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fetch_stall) && $past(rst_n)) |=> fetch_stall);

    assert_stall_ends_in_fix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fetch_stall) && $past(rst_n)) |-> pc_sel[1]);

    assert_nt_never_steers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (POLICY == 2'd1) |-> (pc_sel != 2'd1));

    assert_lost_moves_on_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(flush_ifid)) |-> $stable(lost_cycles));

    assert_lost_step_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (CW'(lost_cycles - $past(lost_cycles)) <= CW'(3)));

endmodule

bind branch_hazard_ctrl bhc_checker #(.POLICY(POLICY), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_sel     (pc_sel),
    .fetch_stall(fetch_stall),
    .flush_ifid (flush_ifid),
    .flush_idex (flush_idex),
    .flush_exmem(flush_exmem),
    .lost_cycles(lost_cycles)
);

// File: tb/branch_hazard_ctrl_tb.sv
// Scoreboard bench: all four policy variants see one stimulus stream; the driver
// queues the expected control word per cycle, the monitor compares at mid-cycle.
module branch_hazard_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int CW = 16;

    localparam logic [5:0] C_IDLE  = 6'b00_0000;
    localparam logic [5:0] C_HOLD  = 6'b00_1100;
    localparam logic [5:0] C_STEER = 6'b01_0100;

    typedef struct {
        logic [3:0][5:0]    ctl;
        logic [3:0][CW-1:0] cnt;
        bit                 chk_cnt;
        logic [AW-1:0]      rpc;
        logic [3:0]         rmask;
        string              tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_is_branch = 1'b0;
    logic id_offset_neg = 1'b0;
    logic mem_taken = 1'b0;
    logic [AW-1:0] mem_target = '0;
    logic [AW-1:0] mem_link_pc = '0;

    logic [1:0]    sel_o   [4];
    logic [AW-1:0] rpc_o   [4];
    logic          stall_o [4];
    logic          fi_o    [4];
    logic          fd_o    [4];
    logic          fe_o    [4];
    logic [CW-1:0] cnt_o   [4];

    exp_t q[$];
    logic [3:0][CW-1:0] run_cnt = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar p = 0; p < 4; p++) begin : g_pol
        branch_hazard_ctrl #(.POLICY(2'(p)), .AW(AW), .CW(CW)) u_dut (
            .clk          (clk),
            .rst_n        (rst_n),
            .id_is_branch (id_is_branch),
            .id_offset_neg(id_offset_neg),
            .mem_taken    (mem_taken),
            .mem_target   (mem_target),
            .mem_link_pc  (mem_link_pc),
            .pc_sel       (sel_o[p]),
            .redirect_pc  (rpc_o[p]),
            .fetch_stall  (stall_o[p]),
            .flush_ifid   (fi_o[p]),
            .flush_idex   (fd_o[p]),
            .flush_exmem  (fe_o[p]),
            .lost_cycles  (cnt_o[p])
        );
    end

    function automatic logic [5:0] fix_word(input logic taken);
        return {taken ? 2'd2 : 2'd3, 4'b0111};
    endfunction

    function automatic string pol_req(input int p);
        case (p)
            0:       return "R2/R3";
            1:       return "R4/R5";
            2:       return "R6/R7";
            default: return "R8";
        endcase
    endfunction

    // Drive one cycle of stimulus and queue what every variant must show in it.
    task automatic step(input logic rs, input logic br, input logic neg, input logic mt,
                        input logic [3:0][5:0] c, input logic [3:0][1:0] inc,
                        input logic [3:0] rmask, input bit chk_cnt, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        rst_n = rs;
        id_is_branch = br;
        id_offset_neg = neg;
        mem_taken = mt;
        e.ctl = c;
        e.cnt = run_cnt;
        e.chk_cnt = chk_cnt;
        e.rpc = mt ? mem_target : mem_link_pc;
        e.rmask = rmask;
        e.tag = tag;
        q.push_back(e);
        for (int p = 0; p < 4; p++) run_cnt[p] = run_cnt[p] + CW'(inc[p]);
    endtask

    task automatic idle(input logic mt, input string tag);
        step(1'b1, 1'b0, 1'b0, mt, {4{C_IDLE}}, '0, 4'b0, 1'b1, tag);
    endtask

    // One isolated branch: decode, execute, memory, then a bubble cycle.
    task automatic branch_scenario(input logic neg, input logic taken,
                                   input logic [AW-1:0] tgt, input logic [AW-1:0] link);
        logic [3:0][5:0] c0, c1, c2;
        logic [3:0][1:0] i0, i2;
        logic [3:0] rm;
        logic pr;
        mem_target = tgt;
        mem_link_pc = link;
        c0[0] = C_HOLD;  i0[0] = 2'd1;
        c1 = {4{C_IDLE}};
        c1[0] = C_HOLD;
        c2[0] = fix_word(taken); i2[0] = 2'd1; rm[0] = 1'b1;
        for (int p = 1; p < 4; p++) begin
            pr = (p == 2) ? 1'b1 : (p == 3) ? neg : 1'b0;
            c0[p] = pr ? C_STEER : C_IDLE;
            i0[p] = pr ? 2'd1 : 2'd0;
            if (pr != taken) begin
                c2[p] = fix_word(taken);
                i2[p] = pr ? 2'd2 : 2'd3;
                rm[p] = 1'b1;
            end else begin
                c2[p] = C_IDLE;
                i2[p] = 2'd0;
                rm[p] = 1'b0;
            end
        end
        step(1'b1, 1'b1, neg, ~taken, c0, i0, 4'b0, 1'b1, "decode");
        step(1'b1, 1'b0, 1'b0, ~taken, c1, {3'b0, 2'd1}, 4'b0, 1'b1, "execute");
        step(1'b1, 1'b0, 1'b0, taken, c2, i2, rm, 1'b1, "resolve R9 R11");
        idle(~taken, "R10 stale outcome");
    endtask

    // Monitor: pop the expectation for this cycle and compare every variant.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [5:0] act;
            e = q.pop_front();
            for (int p = 0; p < 4; p++) begin
                act = {sel_o[p], stall_o[p], fi_o[p], fd_o[p], fe_o[p]};
                checks++;
                if (act !== e.ctl[p]) begin
                    errors++;
                    $display("FAIL %s (%s) policy %0d: control actual=%b expected=%b",
                             pol_req(p), e.tag, p, act, e.ctl[p]);
                end
                if (e.chk_cnt) begin
                    checks++;
                    if (cnt_o[p] !== e.cnt[p]) begin
                        errors++;
                        $display("FAIL R9 (%s) policy %0d: lost_cycles actual=%0d expected=%0d",
                                 e.tag, p, cnt_o[p], e.cnt[p]);
                    end
                end
                if (e.rmask[p]) begin
                    checks++;
                    if (rpc_o[p] !== e.rpc) begin
                        errors++;
                        $display("FAIL R11 (%s) policy %0d: redirect_pc actual=%h expected=%h",
                                 e.tag, p, rpc_o[p], e.rpc);
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: idle state right after reset, with a stray outcome that must be ignored.
        idle(1'b0, "R1 reset");
        idle(1'b1, "R1 R10 no branch");

        // R2 R3 R4 R5 R6 R7 R8 R9 R11: every guess/outcome pairing.
        branch_scenario(1'b0, 1'b0, 32'h0000_1000, 32'h0000_0104);
        branch_scenario(1'b0, 1'b1, 32'h0000_2200, 32'h0000_0208);
        branch_scenario(1'b1, 1'b1, 32'h0000_00F0, 32'h0000_0310);
        branch_scenario(1'b1, 1'b0, 32'h0000_0040, 32'h0000_0420);

        // R10: a younger branch right behind an older one.
        mem_target = 32'h0000_5000;
        mem_link_pc = 32'h0000_0504;
        step(1'b1, 1'b1, 1'b0, 1'b0, {C_IDLE, C_STEER, C_IDLE, C_HOLD},
             {2'd0, 2'd1, 2'd0, 2'd1}, 4'b0, 1'b1, "R10 pair older");
        step(1'b1, 1'b1, 1'b0, 1'b0, {C_IDLE, C_IDLE, C_IDLE, C_HOLD},
             {2'd0, 2'd0, 2'd0, 2'd1}, 4'b0, 1'b1, "R10 pair younger");
        step(1'b1, 1'b0, 1'b0, 1'b1, {fix_word(1'b1), C_IDLE, fix_word(1'b1), fix_word(1'b1)},
             {2'd3, 2'd0, 2'd3, 2'd1}, 4'b1011, 1'b1, "R10 pair resolve");
        idle(1'b1, "R10 squashed younger silent");
        idle(1'b0, "R10 tail");

        // R1: reset in the middle of a run clears the count.
        step(1'b0, 1'b0, 1'b0, 1'b0, {4{C_IDLE}}, '0, 4'b0, 1'b0, "R1 reset asserted");
        run_cnt = '0;
        idle(1'b0, "R1 count cleared");
        idle(1'b0, "R1 settle");

        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule